// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Divider

This block divides one 32-bit integer by another over several clock cycles and returns a quotient and a remainder. Both operands are read as unsigned numbers, or as two's complement numbers when the signed select is high. The core uses restoring long division and settles three quotient bits per cycle through three chained compare/subtract stages. It does not always run a fixed number of iterations. When it accepts a request it counts the leading zeros of both operand magnitudes, works out how many quotient bits can be non-zero, and runs only the cycles those bits need. Small dividends and large divisors therefore finish early.

Some callers need latency that does not depend on the data, for example to close a timing side channel. For them a constant-time input forces every request to the worst-case iteration count, whatever the operands. Division by zero gives a defined result and never stalls.

Requests use a valid/ready handshake. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low while a division runs, and the caller must hold the request until it sees `req_ready`. A `req_valid` raised while `req_ready` is low is ignored. The response side has no back-pressure: `rsp_valid` is high for exactly one cycle, and the caller must capture the quotient and remainder in that cycle.

Top module: `early_term_divider`

## Requirements
- R1: With `req_signed` low, the response holds quotient = floor(dividend / divisor) and remainder = dividend − quotient × divisor, so remainder < divisor.
- R2: With `req_signed` high, the quotient is truncated toward zero and the remainder carries the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF (−1) returns quotient 0x80000000 and remainder 0.
- R3: Latency is measured from the accepting cycle t to the cycle t+L in which `rsp_valid` is high. Define n = clz(|divisor|) − clz(|dividend|) + 1, where clz counts leading zeros of a 32-bit magnitude (0 gives 32) and the magnitudes are the raw values when `req_signed` is low. With `req_const_time` low and divisor non-zero, L = 1 + max(1, ceil(n/3)).
- R4: Latency in the early-terminating mode stays within 2 to 12 cycles. Dividend 0xFFFFFFFF with divisor 1 (unsigned) takes 12 cycles. Dividend 1 with any non-zero divisor takes 2 cycles.
- R5: With `req_const_time` high, every request takes exactly 12 cycles, division by zero included.
- R6: A zero divisor returns quotient 0 and a remainder equal to the dividend bit pattern in both signed and unsigned mode. With `req_const_time` low it takes 2 cycles.
- R7: `rsp_valid` is a single-cycle pulse and is high only in a cycle where a result is due.
- R8: `req_ready` is low from the cycle after acceptance until the response cycle. A `req_valid` presented while `req_ready` is low starts nothing and does not change the result in flight.
- R9: `req_ready` is high in the response cycle, so a new request can be accepted in the same cycle that the previous result is delivered.
- R10: During and right after reset, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Divider idle and able to accept a request |
| req_dividend | input | 32 | Dividend |
| req_divisor | input | 32 | Divisor |
| req_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| req_const_time | input | 1 | 1: always run the worst-case iteration count |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_quotient | output | 32 | Quotient, valid while rsp_valid is high |
| rsp_remainder | output | 32 | Remainder, valid while rsp_valid is high |

## Verification
The bench aims at operands whose leading-zero counts put n exactly on a multiple of three, at n ≤ 0, at n = 32 and at a zero divisor. A design that trimmed the iteration count wrongly, or aligned the dividend wrongly, would show up in two ways: a response one cycle early or late, or quotient bits dropped from the top. Signed cases cover the most-negative dividend, −1 divisors and every sign mix, which exposes a wrong fix-up of the quotient or remainder sign or a magnitude that overflows. A request held during a busy period, and a request presented in the response cycle, show whether a divider latches operands it should ignore or stalls when it could accept.

// File: rtl/etd_pkg.sv
package etd_pkg;

  typedef enum logic [0:0] {
    ETD_IDLE = 1'b0,
    ETD_RUN  = 1'b1
  } etd_state_e;

  // Integer ceiling division used for parameter derivation.
  function automatic int etd_ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/etd_clz.sv
module etd_clz #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);

  // The highest set bit wins because the loop walks upward.
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/etd_prep.sv
module etd_prep
  import etd_pkg::*;
#(
  parameter int W    = 32,
  parameter int R    = 3,
  parameter int KMAX = 11,
  parameter int MW   = 33,
  parameter int CNTW = 4
) (
  input  logic [W-1:0]    dividend,
  input  logic [W-1:0]    divisor,
  input  logic            is_signed,
  input  logic            const_time,
  output logic [W-1:0]    mag_b,
  output logic [W-1:0]    init_rem,
  output logic [MW-1:0]   init_shr,
  output logic [CNTW-1:0] iters,
  output logic            neg_quo,
  output logic            neg_rem,
  output logic            div_zero
);

  localparam int CW = $clog2(W + 1);
  localparam int TW = W + MW;

  logic          a_neg, b_neg;
  logic [W-1:0]  mag_a;
  logic [CW-1:0] clz_a, clz_b;
  logic [TW-1:0] aligned;
  int            sig_bits;
  int            k;
  int            steps;

  assign a_neg    = is_signed & dividend[W-1];
  assign b_neg    = is_signed & divisor[W-1];
  assign mag_a    = a_neg ? (~dividend + 1'b1) : dividend;
  assign mag_b    = b_neg ? (~divisor + 1'b1) : divisor;
  assign div_zero = (divisor == '0);
  assign neg_quo  = a_neg ^ b_neg;
  assign neg_rem  = a_neg;

  etd_clz #(.W(W)) u_clz_a (.vec(mag_a), .zeros(clz_a));
  etd_clz #(.W(W)) u_clz_b (.vec(mag_b), .zeros(clz_b));

  // Number of quotient bits that can be non-zero, then the cycle count.
  always_comb begin
    sig_bits = int'(clz_b) - int'(clz_a) + 1;
    if (const_time) begin
      k = KMAX;
    end else if (div_zero || sig_bits <= 0) begin
      k = 1;
    end else begin
      k = etd_ceil_div(sig_bits, R);
    end
    steps    = k * R;
    // Partial remainder starts as dividend >> steps; the rest is shifted in.
    aligned  = {{MW{1'b0}}, mag_a} << (MW - steps);
    init_rem = aligned[TW-1:MW];
    init_shr = aligned[MW-1:0];
    iters    = CNTW'(k);
  end

endmodule

// File: rtl/etd_step.sv
module etd_step #(
  parameter int W  = 32,
  parameter int MW = 33
) (
  input  logic [W-1:0]  rem_i,
  input  logic [MW-1:0] shr_i,
  input  logic [W-1:0]  quo_i,
  input  logic [W-1:0]  dvs,
  output logic [W-1:0]  rem_o,
  output logic [MW-1:0] shr_o,
  output logic [W-1:0]  quo_o
);

  logic [W:0] trial;
  logic [W:0] diff;
  logic       take;

  // One restoring long-division step.
  always_comb begin
    trial = {rem_i, shr_i[MW-1]};
    diff  = trial - {1'b0, dvs};
    take  = (trial >= {1'b0, dvs});
    rem_o = take ? diff[W-1:0] : trial[W-1:0];
    shr_o = {shr_i[MW-2:0], 1'b0};
    quo_o = {quo_i[W-2:0], take};
  end

endmodule

// File: rtl/etd_fix.sv
module etd_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  input  logic         neg_quo,
  input  logic         neg_rem,
  input  logic         div_zero,
  input  logic [W-1:0] dividend,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  always_comb begin
    if (div_zero) begin
      quo = '0;
      rem = dividend;
    end else begin
      quo = neg_quo ? (~quo_mag + 1'b1) : quo_mag;
      rem = neg_rem ? (~rem_mag + 1'b1) : rem_mag;
    end
  end

endmodule

// File: rtl/early_term_divider.sv
module early_term_divider
  import etd_pkg::*;
#(
  parameter int W = 32,
  parameter int R = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_dividend,
  input  logic [W-1:0] req_divisor,
  input  logic         req_signed,
  input  logic         req_const_time,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_quotient,
  output logic [W-1:0] rsp_remainder
);

  localparam int KMAX = etd_ceil_div(W, R);
  localparam int MW   = KMAX * R;
  localparam int CNTW = $clog2(KMAX + 1);

  etd_state_e      state_q;
  logic [W-1:0]    rem_q, quo_q, dvs_q, dend_q;
  logic [MW-1:0]   shr_q;
  logic [CNTW-1:0] cnt_q;
  logic            neg_quo_q, neg_rem_q, div0_q;
  logic            rsp_valid_q;
  logic [W-1:0]    rsp_quo_q, rsp_rem_q;

  logic [W-1:0]    p_mag_b, p_rem;
  logic [MW-1:0]   p_shr;
  logic [CNTW-1:0] p_iters;
  logic            p_neg_quo, p_neg_rem, p_div0;

  logic [W-1:0]    rem_c [0:R];
  logic [MW-1:0]   shr_c [0:R];
  logic [W-1:0]    quo_c [0:R];
  logic [W-1:0]    fix_quo, fix_rem;
  logic            accept;

  etd_prep #(.W(W), .R(R), .KMAX(KMAX), .MW(MW), .CNTW(CNTW)) u_prep (
    .dividend   (req_dividend),
    .divisor    (req_divisor),
    .is_signed  (req_signed),
    .const_time (req_const_time),
    .mag_b      (p_mag_b),
    .init_rem   (p_rem),
    .init_shr   (p_shr),
    .iters      (p_iters),
    .neg_quo    (p_neg_quo),
    .neg_rem    (p_neg_rem),
    .div_zero   (p_div0)
  );

  assign rem_c[0] = rem_q;
  assign shr_c[0] = shr_q;
  assign quo_c[0] = quo_q;

  for (genvar s = 0; s < R; s++) begin : g_stage
    etd_step #(.W(W), .MW(MW)) u_step (
      .rem_i (rem_c[s]),
      .shr_i (shr_c[s]),
      .quo_i (quo_c[s]),
      .dvs   (dvs_q),
      .rem_o (rem_c[s+1]),
      .shr_o (shr_c[s+1]),
      .quo_o (quo_c[s+1])
    );
  end

  etd_fix #(.W(W)) u_fix (
    .quo_mag  (quo_c[R]),
    .rem_mag  (rem_c[R]),
    .neg_quo  (neg_quo_q),
    .neg_rem  (neg_rem_q),
    .div_zero (div0_q),
    .dividend (dend_q),
    .quo      (fix_quo),
    .rem      (fix_rem)
  );

  assign req_ready = (state_q == ETD_IDLE);
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ETD_IDLE;
      rem_q       <= '0;
      shr_q       <= '0;
      quo_q       <= '0;
      dvs_q       <= '0;
      dend_q      <= '0;
      cnt_q       <= '0;
      neg_quo_q   <= 1'b0;
      neg_rem_q   <= 1'b0;
      div0_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_quo_q   <= '0;
      rsp_rem_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ETD_IDLE: begin
          if (accept) begin
            rem_q     <= p_rem;
            shr_q     <= p_shr;
            quo_q     <= '0;
            dvs_q     <= p_mag_b;
            dend_q    <= req_dividend;
            cnt_q     <= p_iters;
            neg_quo_q <= p_neg_quo;
            neg_rem_q <= p_neg_rem;
            div0_q    <= p_div0;
            state_q   <= ETD_RUN;
          end
        end
        ETD_RUN: begin
          rem_q <= rem_c[R];
          shr_q <= shr_c[R];
          quo_q <= quo_c[R];
          cnt_q <= cnt_q - CNTW'(1);
          if (cnt_q == CNTW'(1)) begin
            state_q     <= ETD_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_quo_q   <= fix_quo;
            rsp_rem_q   <= fix_rem;
          end
        end
        default: state_q <= ETD_IDLE;
      endcase
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_quotient  = rsp_quo_q;
  assign rsp_remainder = rsp_rem_q;

endmodule

// File: rtl/etd_checker.sv
module etd_checker
  import etd_pkg::*;
#(
  parameter int W = 32,
  parameter int R = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic [W-1:0] req_dividend,
  input logic [W-1:0] req_divisor,
  input logic         req_signed,
  input logic         req_const_time,
  input logic         rsp_valid,
  input logic [W-1:0] rsp_quotient,
  input logic [W-1:0] rsp_remainder
);

  localparam int KMAX = etd_ceil_div(W, R);

  logic [15:0]  lat;
  logic [W-1:0] a_l, b_l;
  logic         sg_l, ct_l;
  logic         dz_l;

  assign dz_l = (b_l == '0);

  // Shadow of the accepted request and a latency counter (cycles since acceptance).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat  <= '0;
      a_l  <= '0;
      b_l  <= '0;
      sg_l <= 1'b0;
      ct_l <= 1'b0;
    end else if (req_valid && req_ready) begin
      lat  <= 16'd1;
      a_l  <= req_dividend;
      b_l  <= req_divisor;
      sg_l <= req_signed;
      ct_l <= req_const_time;
    end else if (!req_ready) begin
      lat <= lat + 16'd1;
    end
  end

  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_ready_at_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  assert_lat_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (lat >= 16'd2 && lat <= 16'(KMAX + 1)));

  assert_const_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ct_l) |-> (lat == 16'(KMAX + 1)));

  assert_div_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && dz_l) |-> (rsp_quotient == '0 && rsp_remainder == a_l));

  assert_div_zero_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && dz_l && !ct_l) |-> (lat == 16'd2));

  assert_unsigned_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !sg_l && !dz_l) |->
      (({{W{1'b0}}, rsp_quotient} * {{W{1'b0}}, b_l} + {{W{1'b0}}, rsp_remainder})
         == {{W{1'b0}}, a_l}) && (rsp_remainder < b_l));

endmodule

bind early_term_divider etd_checker #(.W(W), .R(R)) u_etd_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_dividend   (req_dividend),
  .req_divisor    (req_divisor),
  .req_signed     (req_signed),
  .req_const_time (req_const_time),
  .rsp_valid      (rsp_valid),
  .rsp_quotient   (rsp_quotient),
  .rsp_remainder  (rsp_remainder)
);

// File: tb/early_term_divider_tb.sv
module early_term_divider_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_dividend = '0;
  logic [31:0] req_divisor = '0;
  logic        req_signed = 1'b0;
  logic        req_const_time = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_quotient;
  logic [31:0] rsp_remainder;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done_flag = 1'b0;

  // Reference model state.
  bit          m_active = 1'b0;
  int          m_left = 0;
  logic [31:0] m_q, m_r;
  string       m_lat_tag = "R3";
  string       m_val_tag = "R1";

  always #5 clk = ~clk;

  early_term_divider u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_dividend   (req_dividend),
    .req_divisor    (req_divisor),
    .req_signed     (req_signed),
    .req_const_time (req_const_time),
    .rsp_valid      (rsp_valid),
    .rsp_quotient   (rsp_quotient),
    .rsp_remainder  (rsp_remainder)
  );

  function automatic int clz32(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) return 31 - i;
    end
    return 32;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic model_calc(input logic [31:0] a, input logic [31:0] b, input bit sg,
                            input bit ct, output logic [31:0] q, output logic [31:0] r,
                            output int lat);
    longint sa, sb, ma, mb, qq, rr;
    int n, k;
    if (sg) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
    end else begin
      sa = longint'({32'b0, a});
      sb = longint'({32'b0, b});
    end
    ma = (sa < 0) ? -sa : sa;
    mb = (sb < 0) ? -sb : sb;
    if (b == 32'b0) begin
      q = 32'b0;
      r = a;
      lat = ct ? 12 : 2;
    end else begin
      qq = sa / sb;
      rr = sa % sb;
      q = qq[31:0];
      r = rr[31:0];
      n = clz32(mb[31:0]) - clz32(ma[31:0]) + 1;
      k = (n <= 0) ? 1 : (n + 2) / 3;
      lat = ct ? 12 : 1 + k;
    end
  endtask

  // Cycle-by-cycle comparison, sampled away from the rising edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done_flag) begin
      bit exp_valid;
      int lat;
      if (m_active) m_left--;
      exp_valid = m_active && (m_left == 0);
      check(rsp_valid == exp_valid, (m_lat_tag == "") ? "R7" : {m_lat_tag, "/R7"},
            "rsp_valid", 32'(rsp_valid), 32'(exp_valid));
      if (exp_valid && rsp_valid) begin
        check(rsp_quotient == m_q, m_val_tag, "quotient", rsp_quotient, m_q);
        check(rsp_remainder == m_r, m_val_tag, "remainder", rsp_remainder, m_r);
      end
      if (exp_valid) m_active = 1'b0;
      // R8 busy window, R9 ready in the response cycle
      check(req_ready == !m_active, "R8/R9", "req_ready", 32'(req_ready), 32'(!m_active));
      if (req_valid && req_ready) begin
        model_calc(req_dividend, req_divisor, req_signed, req_const_time, m_q, m_r, lat);
        m_active  = 1'b1;
        m_left    = lat;
        m_lat_tag = req_const_time ? "R5" : (req_divisor == 0) ? "R6" : "R3/R4";
        m_val_tag = (req_divisor == 0) ? "R6" : (req_signed ? "R2" : "R1");
      end
    end
  end

  task automatic send(input logic [31:0] a, input logic [31:0] b, input bit sg,
                      input bit ct, input bit junk);
    while (!req_ready) begin
      @(posedge clk);
      #1;
    end
    req_valid      = 1'b1;
    req_dividend   = a;
    req_divisor    = b;
    req_signed     = sg;
    req_const_time = ct;
    @(posedge clk);
    #1;
    if (junk) begin
      // R8: a request offered while busy must be ignored
      req_dividend   = ~a;
      req_divisor    = b + 32'd1;
      req_signed     = ~sg;
      req_const_time = ~ct;
      @(posedge clk);
      #1;
    end
    req_valid = 1'b0;
  endtask

  task automatic drain();
    @(posedge clk);
    #1;
    while (!req_ready) begin
      @(posedge clk);
      #1;
    end
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(req_ready == 1'b1, "R10", "req_ready in reset", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R10", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "req_ready after reset", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R10", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    @(posedge clk);
    #1;

    // R4: longest and shortest early-terminating cases
    send(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0); drain();
    send(32'd1, 32'd1, 1'b0, 1'b0, 1'b0);         drain();
    send(32'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0); drain();
    // R3: n on and around multiples of three, and n below one
    send(32'd100, 32'd7, 1'b0, 1'b0, 1'b0);       drain();
    send(32'h0000_0007, 32'd1, 1'b0, 1'b0, 1'b0); drain();
    send(32'h0000_000F, 32'd1, 1'b0, 1'b0, 1'b0); drain();
    send(32'd5, 32'd9, 1'b0, 1'b0, 1'b0);         drain();
    send(32'h8000_0000, 32'h0001_0000, 1'b0, 1'b0, 1'b0); drain();
    // R6: zero divisor, both modes
    send(32'h1234_5678, 32'd0, 1'b0, 1'b0, 1'b0); drain();
    send(32'h8765_4321, 32'd0, 1'b1, 1'b0, 1'b0); drain();
    send(32'h1234_5678, 32'd0, 1'b0, 1'b1, 1'b0); drain();
    // R2: sign combinations and the overflow case
    send(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0); drain();
    send(-32'sd7, 32'd2, 1'b1, 1'b0, 1'b0);       drain();
    send(32'd7, -32'sd2, 1'b1, 1'b0, 1'b0);       drain();
    send(-32'sd7, -32'sd2, 1'b1, 1'b0, 1'b0);     drain();
    send(32'h8000_0000, 32'd1, 1'b1, 1'b0, 1'b0); drain();
    // R5: constant-time for a short and a long case
    send(32'd1, 32'd1, 1'b0, 1'b1, 1'b0);         drain();
    send(32'hFFFF_FFFF, 32'd3, 1'b0, 1'b1, 1'b0); drain();
    // R8: held request while busy is ignored
    send(32'd1000, 32'd3, 1'b0, 1'b0, 1'b1);      drain();
    // R9: back-to-back requests accepted in the response cycle
    send(32'd50, 32'd5, 1'b0, 1'b0, 1'b0);
    send(32'hDEAD_BEEF, 32'd17, 1'b0, 1'b0, 1'b0);
    send(-32'sd99, 32'd4, 1'b1, 1'b1, 1'b0);
    drain();

    // Random mix with varied leading-zero counts
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      bit sg, ct, jk;
      a  = $urandom() >> ($urandom() % 32);
      b  = $urandom() >> ($urandom() % 32);
      if (($urandom() % 16) == 0) b = 32'd0;
      sg = $urandom() % 2;
      ct = (($urandom() % 4) == 0);
      jk = (($urandom() % 4) == 0);
      send(a, b, sg, ct, jk);
      if (($urandom() % 3) == 0) drain();
    end
    drain();

    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule